// File: doc/BRIEF.md
# I2C Slave with Dual or Masked Address Match

This block is a target-only node for a two-wire serial bus. It watches the clock and data lines, picks out START and STOP conditions, and shifts in the first byte of each transfer. The upper seven bits of that byte are checked against a primary slave address and against a second register. A mode input selects what the second register does. It can hold a second full address, or each of its 1 bits can make the matching bit of the primary address a don't-care, so that a contiguous or scattered range of addresses is answered.

On an accepted address the block acknowledges and then either receives bytes (write) or sends bytes supplied by the host logic (read). The direction comes from the least significant bit of the address byte. The block never drives the data line high and never drives the clock line. It has one output that pulls SDA low. The all-zero general call address is answered only when it is enabled. A pass-all mode hands every address byte to the host logic, and an acknowledge-enable input then decides whether to ACK. The same input also governs 10-bit address headers and received data bytes. Received bytes, loaded transmit bytes, address hits, bus conditions and bit collisions are reported as one-cycle pulses.

Top module: `i2c_mask_slave`

## Requirements
- R1: A fall of SDA while SCL is high raises `start_o` for one cycle, and a rise of SDA while SCL is high raises `stop_o` for one cycle. A START in any state, including a repeated START in the middle of a transfer, restarts address reception.
- R2: An address byte whose bits [7:1] equal `own_addr_i` is acknowledged: SDA is pulled low through the ninth clock. `addr_valid_o` pulses with `addr_byte_o` holding the full byte and `hit_own_o` set.
- R3: When `second_is_mask_i` is 0, an address equal to `second_addr_i` is acknowledged and flagged with `hit_second_o` set.
- R4: When `second_is_mask_i` is 1, any address that equals `own_addr_i` on every bit position where `second_addr_i` holds 0 is acknowledged.
- R5: With matching on, an address that matches nothing and is not a 10-bit header gets no ACK and no `addr_valid_o`. The bytes that follow deliver nothing and are not acknowledged until the next START.
- R6: The address byte 8'h00 is acknowledged and flagged with `hit_gcall_o` only while `gcall_en_i` is 1.
- R7: With `match_all_i` at 1, every address byte raises `addr_valid_o`, and the ACK follows `ack_en_i`.
- R8: An address whose bits [7:3] are 5'b11110 raises `addr_valid_o` with `ten_bit_o` set. It is acknowledged only if `ack_en_i` is 1, unless a hardware match applies.
- R9: In a write, each data byte raises `rx_valid_o` with `rx_byte_o` and is acknowledged when `ack_en_i` is 1. After a NACKed data byte the block ignores the bytes that follow until the next START.
- R10: In a read, `tx_byte_i` is loaded at the end of the ACK slot and at the end of each master ACK, with a `tx_load_o` pulse, and is sent MSB first. A master NACK ends the transmission: SDA stays released and no further load happens.
- R11: While sending a 1 bit, if SDA reads 0 at the rising edge of SCL, `collision_o` pulses and SDA stays released until the next START.
- R12: SDA is only pulled low or released. The pull starts only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| own_addr_i | input | 7 | Primary slave address |
| second_addr_i | input | 7 | Alternate address or don't-care mask |
| second_is_mask_i | input | 1 | 0: alternate address, 1: mask |
| gcall_en_i | input | 1 | Answer the general call address |
| match_all_i | input | 1 | Pass every address to host logic |
| ack_en_i | input | 1 | ACK decision for data, pass-all and 10-bit headers |
| tx_byte_i | input | 8 | Next byte to send in a read |
| tx_load_o | output | 1 | Pulse: `tx_byte_i` was taken |
| rx_byte_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | Pulse: `rx_byte_o` is new |
| addr_valid_o | output | 1 | Pulse: an address byte was flagged |
| addr_byte_o | output | 8 | Last flagged address byte, R/W in bit 0 |
| hit_own_o | output | 1 | Last address matched the primary address |
| hit_second_o | output | 1 | Last address matched through the second register |
| hit_gcall_o | output | 1 | Last address was an enabled general call |
| ten_bit_o | output | 1 | Last address was a 10-bit header |
| start_o | output | 1 | Pulse: START seen |
| stop_o | output | 1 | Pulse: STOP seen |
| collision_o | output | 1 | Pulse: bit collision while sending |

## Verification
The hardest state to reach is a collision in the middle of a read. It needs a master that first wins an address phase in read direction and then contradicts a 1 bit the slave is sending. The bench gets there by addressing the block for a read with an all-ones transmit byte and then driving the first data bit low instead of releasing it. It then clocks the rest of the byte and a further byte to show that the line stays released. The address logic is swept over all 128 addresses in three configurations: dual address, mask with general call, and pass-all. Each expected ACK is computed arithmetically.

// File: rtl/i2c_mask_slave.sv
module i2c_mask_slave #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [6:0] own_addr_i,
  input  logic [6:0] second_addr_i,
  input  logic       second_is_mask_i,
  input  logic       gcall_en_i,
  input  logic       match_all_i,
  input  logic       ack_en_i,
  input  logic [7:0] tx_byte_i,
  output logic       tx_load_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o,
  output logic       addr_valid_o,
  output logic [7:0] addr_byte_o,
  output logic       hit_own_o,
  output logic       hit_second_o,
  output logic       hit_gcall_o,
  output logic       ten_bit_o,
  output logic       start_o,
  output logic       stop_o,
  output logic       collision_o
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RX, S_ACK, S_TX, S_MACK, S_WAIT} st_t;

  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_d, sda_d;
  st_t st, nxt_q;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic ack_q, more_q;

  wire scl_s = scl_sy[SYNC-1];
  wire sda_s = sda_sy[SYNC-1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c  = scl_s & scl_d & ~sda_d & sda_s;

  wire [7:0] byte_in = {sh[6:0], sda_s};
  wire [6:0] a7 = byte_in[7:1];
  wire m_own = (a7 == own_addr_i);
  wire m_sec = second_is_mask_i ? ((a7 & ~second_addr_i) == (own_addr_i & ~second_addr_i))
                                : (a7 == second_addr_i);
  wire m_gc  = gcall_en_i && (byte_in == 8'h00);
  wire tenb  = (a7[6:2] == 5'b11110);
  wire hw_hit = m_own | m_sec | m_gc;
  wire accept = match_all_i ? ack_en_i : (hw_hit | (tenb & ack_en_i));
  wire flag   = match_all_i | hw_hit | tenb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      nxt_q <= S_WAIT;
      cnt <= '0;
      sh <= '0;
      ack_q <= 1'b0;
      more_q <= 1'b0;
      sda_pull_o <= 1'b0;
      tx_load_o <= 1'b0;
      rx_byte_o <= '0;
      rx_valid_o <= 1'b0;
      addr_valid_o <= 1'b0;
      addr_byte_o <= '0;
      hit_own_o <= 1'b0;
      hit_second_o <= 1'b0;
      hit_gcall_o <= 1'b0;
      ten_bit_o <= 1'b0;
      start_o <= 1'b0;
      stop_o <= 1'b0;
      collision_o <= 1'b0;
    end else begin
      tx_load_o <= 1'b0;
      rx_valid_o <= 1'b0;
      addr_valid_o <= 1'b0;
      start_o <= 1'b0;
      stop_o <= 1'b0;
      collision_o <= 1'b0;
      if (start_c) begin
        st <= S_ADDR;
        cnt <= '0;
        sda_pull_o <= 1'b0;
        start_o <= 1'b1;
      end else if (stop_c) begin
        st <= S_IDLE;
        sda_pull_o <= 1'b0;
        stop_o <= 1'b1;
      end else begin
        case (st)
          S_ADDR, S_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              sh <= byte_in;
              cnt <= cnt + 4'd1;
              if (cnt == 4'd7) begin
                if (st == S_ADDR) begin
                  ack_q <= accept;
                  nxt_q <= accept ? (byte_in[0] ? S_TX : S_RX) : S_WAIT;
                  addr_valid_o <= flag;
                  if (flag) begin
                    addr_byte_o <= byte_in;
                    hit_own_o <= m_own;
                    hit_second_o <= m_sec;
                    hit_gcall_o <= m_gc;
                    ten_bit_o <= tenb;
                  end
                end else begin
                  rx_byte_o <= byte_in;
                  rx_valid_o <= 1'b1;
                  ack_q <= ack_en_i;
                  nxt_q <= ack_en_i ? S_RX : S_WAIT;
                end
              end
            end else if (scl_fall && cnt == 4'd8) begin
              st <= S_ACK;
              sda_pull_o <= ack_q;
              cnt <= '0;
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              st <= nxt_q;
              if (nxt_q == S_TX) begin
                sh <= tx_byte_i;
                sda_pull_o <= ~tx_byte_i[7];
                tx_load_o <= 1'b1;
              end else begin
                sda_pull_o <= 1'b0;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              if (!sda_pull_o && !sda_s) begin
                collision_o <= 1'b1;
                st <= S_WAIT;
              end else begin
                cnt <= cnt + 4'd1;
              end
            end else if (scl_fall) begin
              if (cnt == 4'd8) begin
                sda_pull_o <= 1'b0;
                st <= S_MACK;
              end else begin
                sh <= {sh[6:0], 1'b0};
                sda_pull_o <= ~sh[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              more_q <= ~sda_s;
            end else if (scl_fall) begin
              if (more_q) begin
                sh <= tx_byte_i;
                sda_pull_o <= ~tx_byte_i[7];
                tx_load_o <= 1'b1;
                cnt <= '0;
                st <= S_TX;
              end else begin
                st <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_pull_only_scl_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);
  assert_start_stop_exclusive_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_o && stop_o));
  assert_release_on_collision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    collision_o |-> !sda_pull_o);
  assert_flag_needs_reason_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !$past(match_all_i)) |-> (hit_own_o || hit_second_o || hit_gcall_o || ten_bit_o));
  assert_gcall_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit_gcall_o) |-> $past(gcall_en_i));
  assert_no_load_after_collision_R11: assert property (@(posedge clk) disable iff (!rst_n)
    collision_o |=> !tx_load_o);

endmodule

// File: tb/i2c_mask_slave_bench.sv
module i2c_mask_slave_bench;
  localparam int H = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull;
  wire sda_bus = sda_m & ~sda_pull;

  logic [6:0] own_addr = 7'h2A, second_addr = 7'h55;
  logic second_is_mask = 1'b0, gcall_en = 1'b0, match_all = 1'b0, ack_en = 1'b0;
  logic [7:0] tx_byte = 8'h00;
  logic tx_load, rx_valid, addr_valid, hit_own, hit_second, hit_gcall, ten_bit;
  logic start_p, stop_p, collision;
  logic [7:0] rx_byte, addr_byte;

  i2c_mask_slave u_i2c_mask_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_pull_o(sda_pull),
    .own_addr_i(own_addr), .second_addr_i(second_addr), .second_is_mask_i(second_is_mask),
    .gcall_en_i(gcall_en), .match_all_i(match_all), .ack_en_i(ack_en),
    .tx_byte_i(tx_byte), .tx_load_o(tx_load), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .addr_valid_o(addr_valid), .addr_byte_o(addr_byte), .hit_own_o(hit_own),
    .hit_second_o(hit_second), .hit_gcall_o(hit_gcall), .ten_bit_o(ten_bit),
    .start_o(start_p), .stop_o(stop_p), .collision_o(collision));

  int checks = 0, fails = 0;
  int n_start = 0, n_stop = 0, n_addr = 0, n_rx = 0, n_col = 0, n_load = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (start_p) n_start <= n_start + 1;
      if (stop_p) n_stop <= n_stop + 1;
      if (addr_valid) n_addr <= n_addr + 1;
      if (rx_valid) n_rx <= n_rx + 1;
      if (collision) n_col <= n_col + 1;
      if (tx_load) n_load <= n_load + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; wt(2);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic bstop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic wbit(input logic b);
    sda_m = b; wt(H);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H/2);
    b = sda_bus; wt(H - H/2);
    scl_m = 1'b0; wt(2);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    acked = ~b;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(~mack);
  endtask

  task automatic addr_txn(input logic [6:0] a, output logic acked);
    bstart();
    wbyte({a, 1'b0}, acked);
    bstop();
    wt(4);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int s0, p0, a0, r0, c0, l0;
    bit exp_ack, exp_flag, tb10;

    wt(4);
    chk("R12 reset pull", sda_pull, 0);
    chk("R2 reset addr_valid", addr_valid, 0);
    rst_n = 1'b1;
    wt(4);
    chk("R1 no start at reset", n_start, 0);

    // R2/R3/R5/R8 sweep: dual address, ack_en=0
    for (int a = 0; a < 128; a++) begin
      a0 = n_addr;
      addr_txn(a[6:0], ack);
      tb10 = (a[6:2] == 5'b11110);
      exp_ack = (a == 'h2A) || (a == 'h55);
      exp_flag = exp_ack || tb10;
      chk("R3 R5 dual ack", ack, exp_ack);
      chk("R8 dual flag", n_addr - a0, exp_flag);
      if (a == 'h2A) begin
        chk("R2 hit_own", hit_own, 1);
        chk("R2 addr_byte", addr_byte, 8'h54);
      end
      if (a == 'h55) chk("R3 hit_second", {hit_own, hit_second}, 2'b01);
      if (tb10) chk("R8 ten_bit", ten_bit, 1);
    end

    // R4/R6/R8 sweep: mask mode, general call on, ack_en=1
    own_addr = 7'h28; second_addr = 7'h03; second_is_mask = 1'b1;
    gcall_en = 1'b1; ack_en = 1'b1;
    for (int a = 0; a < 128; a++) begin
      a0 = n_addr;
      addr_txn(a[6:0], ack);
      tb10 = (a[6:2] == 5'b11110);
      exp_ack = ((a & 'h7C) == 'h28) || (a == 0) || tb10;
      chk("R4 R6 R8 mask ack", ack, exp_ack);
      chk("R4 mask flag", n_addr - a0, exp_ack);
      if (a == 0) chk("R6 hit_gcall", hit_gcall, 1);
    end
    gcall_en = 1'b0;
    addr_txn(7'h00, ack);
    chk("R6 general call disabled", ack, 0);

    // R7 sweep: pass-all, ack follows ack_en
    match_all = 1'b1;
    for (int a = 0; a < 128; a++) begin
      ack_en = a[0];
      a0 = n_addr;
      addr_txn(a[6:0], ack);
      chk("R7 pass-all ack", ack, a[0]);
      chk("R7 pass-all flag", n_addr - a0, 1);
    end
    match_all = 1'b0;
    own_addr = 7'h2A; second_addr = 7'h55; second_is_mask = 1'b0;

    // R9 write
    ack_en = 1'b1;
    r0 = n_rx;
    bstart();
    wbyte(8'h54, ack); chk("R9 write address ack", ack, 1);
    wbyte(8'hA5, ack); chk("R9 data ack", ack, 1);
    chk("R9 rx_byte A5", rx_byte, 8'hA5);
    wbyte(8'h3C, ack); chk("R9 rx_byte 3C", rx_byte, 8'h3C);
    ack_en = 1'b0;
    wbyte(8'h11, ack); chk("R9 nack data", ack, 0);
    chk("R9 rx_byte 11", rx_byte, 8'h11);
    ack_en = 1'b1;
    wbyte(8'h77, ack); chk("R9 ignored after nack", ack, 0);
    bstop(); wt(4);
    chk("R9 rx count", n_rx - r0, 3);
    chk("R9 rx_byte held", rx_byte, 8'h11);

    // R5 unaddressed write
    r0 = n_rx;
    bstart();
    wbyte(8'h20, ack); chk("R5 no ack", ack, 0);
    wbyte(8'hFF, ack); chk("R5 data ignored", ack, 0);
    bstop(); wt(4);
    chk("R5 no rx", n_rx - r0, 0);

    // R10 read, then R1 repeated start
    s0 = n_start; p0 = n_stop; l0 = n_load;
    tx_byte = 8'h96;
    bstart();
    wbyte(8'h55, ack); chk("R10 read address ack", ack, 1);
    tx_byte = 8'h96;
    for (int i = 7; i >= 0; i--) begin rbit(ack); d[i] = ack; end
    chk("R10 first byte", d, 8'h96);
    tx_byte = 8'h5B;
    wbit(1'b0);
    rbyte(d, 1'b0); chk("R10 second byte", d, 8'h5B);
    rbyte(d, 1'b0); chk("R10 released after nack", d, 8'hFF);
    chk("R10 load count", n_load - l0, 2);
    bstart();
    wbyte(8'hAA, ack); chk("R1 repeated start ack", ack, 1);
    bstop(); wt(4);
    chk("R1 start count", n_start - s0, 2);
    chk("R1 stop count", n_stop - p0, 1);

    // R11 collision
    c0 = n_col; l0 = n_load;
    tx_byte = 8'hFF;
    bstart();
    wbyte(8'h55, ack); chk("R11 read address ack", ack, 1);
    wbit(1'b0);
    wt(2);
    chk("R11 collision flag", n_col - c0, 1);
    d = 8'h00;
    for (int i = 6; i >= 0; i--) begin rbit(ack); d[i] = ack; end
    chk("R11 released rest", d[6:0], 7'h7F);
    wbit(1'b0);
    rbyte(d, 1'b0); chk("R11 stays released", d, 8'hFF);
    chk("R11 no reload", n_load - l0, 1);
    bstop(); wt(4);
    chk("R12 released at end", sda_pull, 0);

    report();
  end
endmodule